// File: doc/BRIEF.md
# Multi-Lane 8b/10b Line Encoder with Per-Group Disparity Override

This block turns a stream of bytes into 10-bit line code groups, one group per lane per clock, using the usual split into a 5-bit-to-6-bit sub-block and a 3-bit-to-4-bit sub-block. Each lane keeps its own running disparity and reports it after every group, so that a downstream serializer sees a DC-balanced stream. A control flag next to each byte selects a special (K) group rather than a data group.

Each lane also has a disparity override. With the override strobe high, the lane ignores its running disparity for that one group and picks the column given by the value bit. The running disparity after that group is derived from the bits actually emitted, and later groups continue from it. The number of lanes is a parameter. Each lane has its own byte, flag, strobe and value bit, and lanes never interact.

Top module: `codegroup_encoder`

## Requirements
- R1: Each lane's code group is 10 bits with sub-block bit `a` at bit 9 down to `j` at bit 0 (six bits `abcdei` in 9..4, four bits `fghj` in 3..0). It follows the standard 8b/10b tables. Examples: K28.5 is 0x0FA in the negative column and 0x305 in the positive column, D21.5 is 0x2AA, D0.0 is 0x274 from a negative and 0x18B from a positive running disparity.
- R2: While `rst_n` is low at a clock edge, every lane's code output, running disparity and error flag go to 0. A running disparity of 0 means negative, so the first group after reset uses the negative column.
- R3: Each code group, running disparity and error flag appear on the outputs one clock edge after the byte, flag, strobe and value bit are presented. Strobe and value are sampled together with the byte they act on.
- R4: With the override strobe low, an unbroken run of K28.5 groups alternates between 0x0FA and 0x305.
- R5: With the strobe high and the value bit 0, the lane encodes from the positive column (K28.5 gives 0x305) whatever its running disparity. With the strobe low, the value bit has no effect.
- R6: With the strobe high and the value bit 1, the lane encodes from the negative column (K28.5 gives 0x0FA) whatever its running disparity.
- R7: After every group, forced or not, the running disparity output is the column used for that group (1 = positive), inverted if the emitted group does not hold exactly five ones. An unforced group leaves from a negative disparity with at least five ones and from a positive one with at most five ones.
- R8: D.x.7 uses the alternate 4-bit form (0111 or 1000) for x = 17, 18, 20 when the disparity entering the 4-bit sub-block is negative, and for x = 11, 13, 14 when it is positive. Otherwise it uses the primary form (1110 or 0001). Example: D17.7 is 0x231 from a positive and 0x237 from a negative running disparity.
- R9: With the control flag set, the accepted bytes are K28.0 to K28.7 (low five bits 11100) and K23.7, K27.7, K29.7, K30.7 (bytes 0xF7, 0xFB, 0xFD, 0xFE). Any other byte flagged as control raises that lane's error output for its group and is encoded as the data group of the same byte.
- R10: The strobe and value bit of one lane change only that lane's code group and running disparity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_in | input | LANES | Per lane: 1 = byte is a K group |
| byte_in | input | 8*LANES | Per lane byte, lane i in bits 8i+7..8i, HGF EDCBA order (EDCBA = x, HGF = y) |
| disp_force | input | LANES | Per lane override strobe for the current group |
| disp_value | input | LANES | Per lane column when forced: 1 = negative, 0 = positive |
| code_out | output | 10*LANES | Per lane code group, lane i in bits 10i+9..10i |
| rd_out | output | LANES | Per lane running disparity after the group on code_out, 1 = positive |
| kerr_out | output | LANES | Per lane flag: the group came from an invalid control byte |

## Verification
Two things can happen to a lane in the same cycle: the override picks the column, and the table lookup decides whether the 6-bit and 4-bit sub-blocks are complemented, including the D.x.7 alternate choice. The bench forces both columns on balanced and unbalanced groups. Some forced groups agree with the lane's current disparity and others oppose it, and one unbalanced data byte is forced negative while the lane sits positive. Each group is judged on both the exact 10-bit value and the running disparity that follows it, so a wrong column, a wrong sub-block complement, or a disparity update taken from the old state instead of the emitted bits each shows up. A second lane runs an unforced comma stream alongside and is then forced while the first lane is not, which checks that the override acts on its own lane only.

// File: rtl/codegroup_pkg.sv
// Shared widths and sub-block lookup functions for the 8b/10b line encoder.
// Assumes byte bit order HGFEDCBA, with EDCBA feeding the 6-bit sub-block.
package codegroup_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 10;
    localparam int X_W    = 5;
    localparam int Y_W    = 3;

    // Negative-column 6-bit form (abcdei) for data value x.
    function automatic logic [5:0] six_neg(input logic [X_W-1:0] x);
        logic [5:0] r;
        case (x)
            5'd0:  r = 6'b100111;  5'd1:  r = 6'b011101;
            5'd2:  r = 6'b101101;  5'd3:  r = 6'b110001;
            5'd4:  r = 6'b110101;  5'd5:  r = 6'b101001;
            5'd6:  r = 6'b011001;  5'd7:  r = 6'b111000;
            5'd8:  r = 6'b111001;  5'd9:  r = 6'b100101;
            5'd10: r = 6'b010101;  5'd11: r = 6'b110100;
            5'd12: r = 6'b001101;  5'd13: r = 6'b101100;
            5'd14: r = 6'b011100;  5'd15: r = 6'b010111;
            5'd16: r = 6'b011011;  5'd17: r = 6'b100011;
            5'd18: r = 6'b010011;  5'd19: r = 6'b110010;
            5'd20: r = 6'b001011;  5'd21: r = 6'b101010;
            5'd22: r = 6'b011010;  5'd23: r = 6'b111010;
            5'd24: r = 6'b110011;  5'd25: r = 6'b100110;
            5'd26: r = 6'b010110;  5'd27: r = 6'b110110;
            5'd28: r = 6'b001110;  5'd29: r = 6'b101110;
            5'd30: r = 6'b011110;  default: r = 6'b101011;
        endcase
        return r;
    endfunction

    // Negative-column 4-bit form (fghj) for y; kmode selects the control set.
    function automatic logic [3:0] four_neg(input logic [Y_W-1:0] y,
                                            input logic kmode,
                                            input logic alt7);
        logic [3:0] r;
        case (y)
            3'd0: r = 4'b1011;
            3'd1: r = kmode ? 4'b0110 : 4'b1001;
            3'd2: r = kmode ? 4'b1010 : 4'b0101;
            3'd3: r = 4'b1100;
            3'd4: r = 4'b1101;
            3'd5: r = kmode ? 4'b0101 : 4'b1010;
            3'd6: r = kmode ? 4'b1001 : 4'b0110;
            default: r = (kmode || alt7) ? 4'b0111 : 4'b1110;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cg_six_stage.sv
// 6-bit sub-block: maps x (EDCBA) to abcdei given the entering disparity.
// Assumes k28 is set only for an accepted K28.y group. Purely combinational.
module cg_six_stage
    import codegroup_pkg::*;
(
    input  logic [X_W-1:0] x_in,
    input  logic           k28,
    input  logic           rd_in,
    output logic [5:0]     six_out,
    output logic           rd_mid
);
    logic [5:0] base;
    logic       unbal;
    logic       flip;

    // Pick the negative-column form, then complement it on a positive disparity where needed.
    always_comb begin
        base    = k28 ? 6'b001111 : six_neg(x_in);
        unbal   = ($countones(base) != 3);
        flip    = rd_in && (unbal || (!k28 && x_in == 5'd7));
        six_out = flip ? ~base : base;
        rd_mid  = rd_in ^ unbal;
    end
endmodule

// File: rtl/cg_four_stage.sv
// 4-bit sub-block: maps y (HGF) to fghj given the disparity after the 6-bit part.
// Assumes kmode is set only for accepted control groups; x selects the D.x.7 alternate.
module cg_four_stage
    import codegroup_pkg::*;
(
    input  logic [Y_W-1:0] y_in,
    input  logic [X_W-1:0] x_in,
    input  logic           kmode,
    input  logic           rd_mid,
    output logic [3:0]     four_out,
    output logic           rd_end
);
    logic [3:0] base;
    logic       alt7;
    logic       unbal;
    logic       flip;

    // Choose the 7-form to avoid a run of five, look up, then complement for a positive disparity.
    always_comb begin
        alt7  = (!rd_mid && (x_in == 5'd17 || x_in == 5'd18 || x_in == 5'd20)) ||
                ( rd_mid && (x_in == 5'd11 || x_in == 5'd13 || x_in == 5'd14));
        base  = four_neg(y_in, kmode, alt7);
        unbal = ($countones(base) != 2);
        flip  = rd_mid && (unbal || kmode || y_in == 3'd3);
        four_out = flip ? ~base : base;
        rd_end   = rd_mid ^ unbal;
    end
endmodule

// File: rtl/cg_lane.sv
// One encoder lane: validates control bytes, applies the disparity override,
// encodes through the two sub-blocks and registers the group and disparity.
// Assumes a synchronous active-low reset; one cycle from input to output.
module cg_lane
    import codegroup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic              force_en,
    input  logic              force_val,
    output logic [CODE_W-1:0] code_q,
    output logic              rd_q,
    output logic              kerr_q
);
    logic [X_W-1:0] x;
    logic [Y_W-1:0] y;
    logic           k_ok;
    logic           rd_use;
    logic [5:0]     six;
    logic [3:0]     four;
    logic           rd_m;
    logic           rd_n;

    // Split the byte, check the control set and choose the column for this group.
    always_comb begin
        x      = byte_val[X_W-1:0];
        y      = byte_val[BYTE_W-1:X_W];
        k_ok   = ctrl && ((x == 5'd28) ||
                 (y == 3'd7 && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30)));
        rd_use = force_en ? ~force_val : rd_q;
    end

    cg_six_stage u_six (
        .x_in    (x),
        .k28     (k_ok && x == 5'd28),
        .rd_in   (rd_use),
        .six_out (six),
        .rd_mid  (rd_m)
    );

    cg_four_stage u_four (
        .y_in     (y),
        .x_in     (x),
        .kmode    (k_ok),
        .rd_mid   (rd_m),
        .four_out (four),
        .rd_end   (rd_n)
    );

    // Register the emitted group, the disparity it leaves behind and the control error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            rd_q   <= 1'b0;
            kerr_q <= 1'b0;
        end else begin
            code_q <= {six, four};
            rd_q   <= rd_n;
            kerr_q <= ctrl && !k_ok;
        end
    end
endmodule

// File: rtl/codegroup_encoder.sv
// Top level: LANES independent 8b/10b lanes with per-lane disparity override.
// Assumes lane i occupies slice i of every bus; lanes share only clock and reset.
module codegroup_encoder
    import codegroup_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [LANES-1:0]         ctrl_in,
    input  logic [LANES*BYTE_W-1:0]  byte_in,
    input  logic [LANES-1:0]         disp_force,
    input  logic [LANES-1:0]         disp_value,
    output logic [LANES*CODE_W-1:0]  code_out,
    output logic [LANES-1:0]         rd_out,
    output logic [LANES-1:0]         kerr_out
);
    // One lane instance per slice of the buses.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        cg_lane u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl      (ctrl_in[i]),
            .byte_val  (byte_in[i*BYTE_W +: BYTE_W]),
            .force_en  (disp_force[i]),
            .force_val (disp_value[i]),
            .code_q    (code_out[i*CODE_W +: CODE_W]),
            .rd_q      (rd_out[i]),
            .kerr_q    (kerr_out[i])
        );
    end
endmodule

// File: rtl/codegroup_encoder_chk.sv
// Property checker for codegroup_encoder, bound to every instance of it.
// Assumes the top's port names; only ports are observed.
module codegroup_encoder_chk
    import codegroup_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [LANES-1:0]         ctrl_in,
    input logic [LANES-1:0]         disp_force,
    input logic [LANES-1:0]         disp_value,
    input logic [LANES*CODE_W-1:0]  code_out,
    input logic [LANES-1:0]         rd_out,
    input logic [LANES-1:0]         kerr_out
);
    logic primed;

    // Marks cycles whose outputs came from a non-reset input cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        logic [3:0] ones;
        assign ones = 4'($countones(code_out[i*CODE_W +: CODE_W]));

        p_weight_r1: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (ones >= 4'd4 && ones <= 4'd6));

        p_rd_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && !$past(disp_force[i])) |->
            (rd_out[i] == ($past(rd_out[i]) ^ (ones != 4'd5))));

        p_rd_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && $past(disp_force[i])) |->
            (rd_out[i] == (!$past(disp_value[i]) ^ (ones != 4'd5))));

        p_column_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (primed && !$past(disp_force[i])) |->
            ($past(rd_out[i]) ? (ones <= 4'd5) : (ones >= 4'd5)));

        p_kerr_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
            kerr_out[i] |-> (primed && $past(ctrl_in[i])));
    end
endmodule

bind codegroup_encoder codegroup_encoder_chk #(.LANES(LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_in    (ctrl_in),
    .disp_force (disp_force),
    .disp_value (disp_value),
    .code_out   (code_out),
    .rd_out     (rd_out),
    .kerr_out   (kerr_out)
);

// File: tb/codegroup_encoder_test.sv
// Bench: a vector table on lane 0 with a free-running comma stream on lane 1,
// then directed tests for latency, lane isolation and reset mid-stream.
module codegroup_encoder_test;
    localparam int LANES = 2;
    localparam int NV    = 18;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [LANES-1:0]     ctrl_in = '0;
    logic [LANES*8-1:0]   byte_in = '0;
    logic [LANES-1:0]     disp_force = '0;
    logic [LANES-1:0]     disp_value = '0;
    logic [LANES*10-1:0]  code_out;
    logic [LANES-1:0]     rd_out;
    logic [LANES-1:0]     kerr_out;

    int n_chk = 0;
    int n_bad = 0;
    logic l1_rd = 1'b0;

    always #10 clk = ~clk;

    codegroup_encoder #(.LANES(LANES)) uut (.*);

    // {ctrl, byte, force, value, expected code, expected rd, expected err}
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 8'hBC, 1'b0, 1'b0, 10'h0FA, 1'b1, 1'b0},
        {1'b1, 8'hBC, 1'b0, 1'b0, 10'h305, 1'b0, 1'b0},
        {1'b1, 8'hBC, 1'b1, 1'b0, 10'h305, 1'b0, 1'b0},
        {1'b1, 8'hBC, 1'b0, 1'b0, 10'h0FA, 1'b1, 1'b0},
        {1'b1, 8'hBC, 1'b1, 1'b1, 10'h0FA, 1'b1, 1'b0},
        {1'b0, 8'hB5, 1'b0, 1'b1, 10'h2AA, 1'b1, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b0, 10'h18B, 1'b1, 1'b0},
        {1'b0, 8'hF1, 1'b0, 1'b0, 10'h231, 1'b0, 1'b0},
        {1'b0, 8'hF1, 1'b0, 1'b0, 10'h237, 1'b1, 1'b0},
        {1'b0, 8'hEB, 1'b0, 1'b0, 10'h348, 1'b0, 1'b0},
        {1'b0, 8'h67, 1'b0, 1'b0, 10'h38C, 1'b0, 1'b0},
        {1'b1, 8'hF7, 1'b0, 1'b0, 10'h3A8, 1'b0, 1'b0},
        {1'b1, 8'hFC, 1'b0, 1'b0, 10'h0F8, 1'b0, 1'b0},
        {1'b1, 8'h00, 1'b0, 1'b0, 10'h274, 1'b0, 1'b1},
        {1'b1, 8'h3C, 1'b0, 1'b0, 10'h0F9, 1'b1, 1'b0},
        {1'b0, 8'h23, 1'b0, 1'b0, 10'h319, 1'b1, 1'b0},
        {1'b0, 8'hC5, 1'b1, 1'b0, 10'h296, 1'b1, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b1, 10'h274, 1'b0, 1'b0}
    };

    // Requirement tag for each table row.
    function automatic string tag_of(input int i);
        case (i)
            0, 1, 3:   return "R4";
            2, 16:     return "R5";
            4, 17:     return "R6";
            5:         return "R5 value ignored";
            6, 10, 15: return "R1";
            7, 8, 9:   return "R8";
            11, 12, 13, 14: return "R9";
            default:   return "R7";
        endcase
    endfunction

    // Compare one value and report a mismatch.
    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%03h expected 0x%03h", req, act, exp);
        end
    endtask

    // Drive both lanes at the falling edge, then wait past the next rising edge.
    task automatic step(input logic c0, input logic [7:0] b0, input logic f0, input logic v0,
                        input logic c1, input logic [7:0] b1, input logic f1, input logic v1);
        @(negedge clk);
        ctrl_in    = {c1, c0};
        byte_in    = {b1, b0};
        disp_force = {f1, f0};
        disp_value = {v1, v0};
        @(posedge clk);
        #2;
    endtask

    initial begin : watchdog
        repeat (2000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic exp_l1;
        repeat (3) @(posedge clk);
        #2;
        // R2: reset state
        check("R2 code", code_out[9:0], 10'h000);
        check("R2 rd/err", {8'h00, rd_out[0], kerr_out[0]}, 10'h000);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk on lane 0; lane 1 runs unforced K28.5 with a toggling value bit.
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][22], VEC[i][21:14], VEC[i][13], VEC[i][12],
                 1'b1, 8'hBC, 1'b0, i[0]);
            check(tag_of(i), code_out[9:0], VEC[i][11:2]);
            check({tag_of(i), " R7 rd"}, {9'd0, rd_out[0]}, {9'd0, VEC[i][1]});
            check("R9 kerr", {9'd0, kerr_out[0]}, {9'd0, VEC[i][0]});
            check("R4 lane1", code_out[19:10], l1_rd ? 10'h305 : 10'h0FA);
            l1_rd = ~l1_rd;
            check("R7 lane1 rd", {9'd0, rd_out[1]}, {9'd0, l1_rd});
        end

        // R10: force lane 1 to the negative column; lane 0 runs unforced.
        exp_l1 = 1'b1;
        step(1'b1, 8'hBC, 1'b0, 1'b0, 1'b1, 8'hBC, 1'b1, 1'b1);
        check("R10 lane0", code_out[9:0], 10'h0FA);
        check("R10 lane1", code_out[19:10], 10'h0FA);
        check("R10 lane1 rd", {9'd0, rd_out[1]}, {9'd0, exp_l1});

        // R3: output holds until the clock edge after the input changes.
        @(negedge clk);
        ctrl_in = 2'b01;
        byte_in = {8'hBC, 8'hB5};
        disp_force = '0;
        #2;
        check("R3 hold", code_out[9:0], 10'h0FA);
        @(posedge clk);
        #2;
        check("R3 update", code_out[9:0], 10'h2AA);

        // R2: reset mid-stream, then the first group uses the negative column.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R2 mid code", code_out[9:0], 10'h000);
        check("R2 mid rd", {9'd0, rd_out[0]}, 10'h000);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 8'hBC, 1'b0, 1'b0, 1'b1, 8'hBC, 1'b0, 1'b0);
        check("R2 first group", code_out[9:0], 10'h0FA);
        check("R2 first lane1", code_out[19:10], 10'h0FA);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule